// File: doc/BRIEF.md
# March Memory Self-Test Sequencer

This block is the control heart of a built-in self-test for a single-port RAM whose write-data and read-data travel on separate buses. A state machine, not a random source, produces every access. Once started, it sweeps the whole address space four times. Each sweep is a march element with a fixed direction and a fixed list of operations. The data background is either all zeros or all ones across the data width.

The four elements run in this order:
- ascending, write zeros;
- ascending, read zeros then write ones;
- descending, read ones then write zeros;
- descending, read zeros.

Each read is compared against its expected background one cycle later, when the RAM returns the word. Any mismatch latches a sticky failure flag. A one-cycle done pulse marks the end of the test.

States are `ST_IDLE`, `ST_M0_WR`, `ST_M1_RD`, `ST_M1_WR`, `ST_M2_RD`, `ST_M2_WR`, `ST_M3_RD` and `ST_DONE`. The transitions are:
- `ST_IDLE`→`ST_M0_WR` on start.
- `ST_M0_WR` loops until the address is all ones, then goes to `ST_M1_RD`.
- `ST_M1_RD`→`ST_M1_WR`, which returns to `ST_M1_RD`. At the all-ones address it goes to `ST_M2_RD` instead.
- `ST_M2_RD`→`ST_M2_WR`, which returns to `ST_M2_RD`. At address zero it goes to `ST_M3_RD` instead.
- `ST_M3_RD` loops until address zero, then goes to `ST_DONE`.
- `ST_DONE`→`ST_IDLE`.

A synchronous clear, active high, returns the machine to `ST_IDLE` from any state.

Top module: `march_bist_gen`

## Requirements
- R1: While `clr` is high at a rising edge, the next cycle shows `mem_we`=0, `mem_re`=0, `mem_addr`=0, `done`=0 and `fail`=0, with the machine idle.
- R2: `start` sampled high in idle begins the test in the next cycle. `start` raised while a test runs has no effect on the access sequence.
- R3: Element 0 writes the all-zero word to addresses 0,1,…,N-1, one address per cycle, with N = 2^ADDR_W.
- R4: Element 1 visits addresses 0 to N-1 in ascending order. Each address gets a read cycle (`mem_re`=1), followed by a write cycle of the all-ones word.
- R5: Element 2 visits addresses N-1 down to 0. Each address gets a read cycle, followed by a write cycle of the all-zero word.
- R6: Element 3 reads addresses N-1 down to 0, one per cycle. After it, both enables stay low.
- R7: `mem_rdata` is compared in the cycle after each read-enable cycle. The expected word is all ones for element 2 reads and all zeros otherwise. A mismatch raises `fail` two cycles after the read-enable cycle.
- R8: `fail` stays high through done, idle and a new start. Only `clr` lowers it.
- R9: With start sampled in cycle c, `done` is high only in cycle c+6N+2, for exactly one cycle. `fail` already reflects the compare of the final read in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| clr | input | 1 | Synchronous clear, active high |
| start | input | 1 | Begin a test when idle |
| mem_addr | output | ADDR_W | RAM address |
| mem_wdata | output | DATA_W | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DATA_W | RAM read data, valid the cycle after `mem_re` |
| fail | output | 1 | Sticky mismatch flag |
| done | output | 1 | One-cycle end-of-test pulse |

## Verification
The final read of element 3, at address 0, is compared in the same cycle in which the done pulse is being registered. A late miscompare and done therefore land on the outputs together. The bench provokes this with a RAM model in which a write of 0 over a 1 fails in one bit of address 0. Only the last read can catch that fault. The bench requires `fail` to be low in the cycle before `done` and high in the `done` cycle. Sweeps of stuck-at-0 and stuck-at-1 faults over every address confirm that the rise of `fail` lands two cycles after the read cycle that the fault's position implies.

// File: rtl/march_pkg.sv
package march_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_M0_WR,
        ST_M1_RD,
        ST_M1_WR,
        ST_M2_RD,
        ST_M2_WR,
        ST_M3_RD,
        ST_DONE
    } march_state_e;
endpackage

// File: rtl/march_addr_ctr.sv
module march_addr_ctr #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              step,
    input  logic              down,
    output logic [ADDR_W-1:0] addr,
    output logic              last
);
    localparam logic [ADDR_W-1:0] ADDR_TOP = {ADDR_W{1'b1}};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (clr)
            addr_q <= '0;
        else if (step)
            addr_q <= down ? addr_q - 1'b1 : addr_q + 1'b1;
    end

    assign addr = addr_q;
    // terminal address depends on sweep direction
    assign last = down ? (addr_q == '0) : (addr_q == ADDR_TOP);
endmodule

// File: rtl/march_cmp.sv
module march_cmp #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              rd_en,
    input  logic              exp_ones,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail
);
    logic              chk_q;
    logic [DATA_W-1:0] exp_q;
    logic              fail_q;

    // expected word is delayed to line up with the RAM's read latency
    always_ff @(posedge clk) begin
        if (clr) begin
            chk_q <= 1'b0;
            exp_q <= '0;
        end else begin
            chk_q <= rd_en;
            exp_q <= exp_ones ? {DATA_W{1'b1}} : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (clr)
            fail_q <= 1'b0;
        else if (chk_q && (rdata != exp_q))
            fail_q <= 1'b1;
    end

    assign fail = fail_q;
endmodule

// File: rtl/march_fsm.sv
module march_fsm
    import march_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic start,
    input  logic addr_last,
    output logic wr_en,
    output logic rd_en,
    output logic wr_ones,
    output logic exp_ones,
    output logic step,
    output logic down,
    output logic done
);
    march_state_e state_q, state_d;
    logic         done_q;

    // state register
    always_ff @(posedge clk) begin
        if (clr) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_DONE);
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_M0_WR;
            ST_M0_WR: if (addr_last) state_d = ST_M1_RD;
            ST_M1_RD: state_d = ST_M1_WR;
            ST_M1_WR: state_d = addr_last ? ST_M2_RD : ST_M1_RD;
            ST_M2_RD: state_d = ST_M2_WR;
            ST_M2_WR: state_d = addr_last ? ST_M3_RD : ST_M2_RD;
            ST_M3_RD: if (addr_last) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs (Moore)
    always_comb begin
        wr_en    = 1'b0;
        rd_en    = 1'b0;
        wr_ones  = 1'b0;
        exp_ones = 1'b0;
        step     = 1'b0;
        down     = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_M0_WR: begin
                wr_en = 1'b1;
                step  = 1'b1;          // wraps all-ones to zero for element 1
            end
            ST_M1_RD: rd_en = 1'b1;
            ST_M1_WR: begin
                wr_en   = 1'b1;
                wr_ones = 1'b1;
                step    = !addr_last;  // element 2 starts at the top
            end
            ST_M2_RD: begin
                rd_en    = 1'b1;
                exp_ones = 1'b1;
                down     = 1'b1;
            end
            ST_M2_WR: begin
                wr_en = 1'b1;
                down  = 1'b1;
                step  = 1'b1;          // wraps zero to all-ones for element 3
            end
            ST_M3_RD: begin
                rd_en = 1'b1;
                down  = 1'b1;
                step  = !addr_last;    // park at zero
            end
            ST_DONE: ;
            default: ;
        endcase
    end

    assign done = done_q;
endmodule

// File: rtl/march_bist_gen.sv
module march_bist_gen #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              clr,
    input  logic              start,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic              mem_re,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              fail,
    output logic              done
);
    logic wr_ones, exp_ones, step, down, addr_last;

    march_fsm u_fsm (
        .clk      (clk),
        .clr      (clr),
        .start    (start),
        .addr_last(addr_last),
        .wr_en    (mem_we),
        .rd_en    (mem_re),
        .wr_ones  (wr_ones),
        .exp_ones (exp_ones),
        .step     (step),
        .down     (down),
        .done     (done)
    );

    march_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk (clk),
        .clr (clr),
        .step(step),
        .down(down),
        .addr(mem_addr),
        .last(addr_last)
    );

    march_cmp #(.DATA_W(DATA_W)) u_cmp (
        .clk     (clk),
        .clr     (clr),
        .rd_en   (mem_re),
        .exp_ones(exp_ones),
        .rdata   (mem_rdata),
        .fail    (fail)
    );

    assign mem_wdata = wr_ones ? {DATA_W{1'b1}} : '0;
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              clr,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_we,
    input logic              mem_re,
    input logic              fail,
    input logic              done
);
    assert_clr_idle_R1: assert property (@(posedge clk)
        clr |=> (!mem_we && !mem_re && !done && !fail && mem_addr == '0));

    assert_up_write_step_R3: assert property (@(posedge clk) disable iff (clr)
        (mem_we && $past(mem_we) && !$past(clr)) |->
            (mem_addr == $past(mem_addr) + ADDR_W'(1)));

    assert_down_read_step_R6: assert property (@(posedge clk) disable iff (clr)
        (mem_re && $past(mem_re) && !$past(clr)) |->
            (mem_addr == $past(mem_addr) - ADDR_W'(1)));

    assert_fail_sticky_R8: assert property (@(posedge clk) disable iff (clr)
        fail |=> fail);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (clr)
        done |=> !done);

    assert_done_quiet_R9: assert property (@(posedge clk) disable iff (clr)
        done |-> (!mem_we && !mem_re));
endmodule

bind march_bist_gen march_bist_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk     (clk),
    .clr     (clr),
    .mem_addr(mem_addr),
    .mem_we  (mem_we),
    .mem_re  (mem_re),
    .fail    (fail),
    .done    (done)
);

// File: tb/march_bist_gen_tb.sv
`timescale 1ns/1ps
module march_bist_gen_tb;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;
    localparam int TOT = 6 * N;

    logic          clk = 1'b0;
    logic          clr = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic          mem_we, mem_re;
    logic [DW-1:0] mem_rdata;
    logic          fail, done;

    int vectors = 0;
    int miscompares = 0;

    // fault model: 0 none, 1 stuck-at-0, 2 stuck-at-1, 3 failed 1->0 write
    int fmode = 0;
    int faddr = 0;
    int fbit  = 0;

    logic [DW-1:0] mem [N];

    always #5 clk = ~clk;

    march_bist_gen #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .clr(clr), .start(start),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_we(mem_we), .mem_re(mem_re), .mem_rdata(mem_rdata),
        .fail(fail), .done(done)
    );

    always @(posedge clk) begin
        if (mem_we) begin
            logic [DW-1:0] w;
            w = mem_wdata;
            if (fmode == 3 && int'(mem_addr) == faddr && mem[mem_addr][fbit] && !w[fbit])
                w[fbit] = 1'b1;
            mem[mem_addr] <= w;
        end
        if (mem_re) begin
            logic [DW-1:0] r;
            r = mem[mem_addr];
            if (int'(mem_addr) == faddr) begin
                if (fmode == 1) r[fbit] = 1'b0;
                if (fmode == 2) r[fbit] = 1'b1;
            end
            mem_rdata <= r;
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: run did not end, actual=hung expected=finished");
        summary();
        $finish;
    end

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clr = 1'b1;
        @(negedge clk); clr = 1'b0;
        chk("R1 we",   32'(mem_we), 0);
        chk("R1 re",   32'(mem_re), 0);
        chk("R1 addr", 32'(mem_addr), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 fail", 32'(fail), 0);
    endtask

    // expected access in op cycle i (1..TOT): we, re, addr, write data ones
    task automatic exp_op(int i, output logic we, output logic re,
                          output int a, output logic ones);
        int j;
        we = 0; re = 0; a = 0; ones = 0;
        if (i <= N) begin
            we = 1; a = i - 1;
        end else if (i <= 3 * N) begin
            j = i - 1 - N; a = j / 2;
            if (j % 2 == 0) re = 1; else begin we = 1; ones = 1; end
        end else if (i <= 5 * N) begin
            j = i - 1 - 3 * N; a = N - 1 - j / 2;
            if (j % 2 == 0) re = 1; else we = 1;
        end else begin
            j = i - 1 - 5 * N; a = N - 1 - j; re = 1;
        end
    endtask

    // full run; det = op cycle of the read expected to catch the fault (0: none)
    task automatic run_march(int mode, int fa, int fb, int det, bit pulse, bit seq);
        logic ewe, ere, eones;
        int   ea;
        fmode = mode; faddr = fa; fbit = fb;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int i = 1; i <= TOT + 3; i++) begin
            if (seq) begin
                if (i <= TOT) exp_op(i, ewe, ere, ea, eones);
                else begin ewe = 0; ere = 0; ea = 0; eones = 0; end
                chk(i <= N ? "R3 we" : i <= 3*N ? "R4 we" : i <= 5*N ? "R5 we" : "R6 we",
                    32'(mem_we), 32'(ewe));
                chk(i <= N ? "R3 re" : i <= 3*N ? "R4 re" : i <= 5*N ? "R5 re" : "R6 re",
                    32'(mem_re), 32'(ere));
                if (i <= TOT) begin
                    chk("R2 addr sequence", 32'(mem_addr), 32'(ea));
                    if (ewe) chk("R4 wdata", 32'(mem_wdata), eones ? 32'(8'hFF) : 0);
                end
            end
            chk("R7 fail timing", 32'(fail), (det != 0 && i >= det + 2) ? 1 : 0);
            chk("R9 done", 32'(done), (i == TOT + 2) ? 1 : 0);
            start = (pulse && i == 10) ? 1'b1 : 1'b0;
            @(negedge clk);
        end
        fmode = 0;
    endtask

    initial begin
        mem_rdata = '0;
        for (int k = 0; k < N; k++) mem[k] = DW'(k * 37 + 5);
        repeat (3) @(negedge clk);
        do_clear();

        // fault-free, full sequence check, start pulsed mid-run (R2)
        run_march(0, 0, 0, 0, 1'b1, 1'b1);
        run_march(0, 0, 0, 0, 1'b0, 1'b1);

        // stuck-at-1: caught by element 1 read of the address (R7)
        for (int a = 0; a < N; a++) begin
            do_clear();
            run_march(2, a, a % DW, N + 2 * a + 1, 1'b0, 1'b0);
        end
        // stuck-at-0: caught by element 2 read of the address (R7)
        for (int a = 0; a < N; a++) begin
            do_clear();
            run_march(1, a, (a + 3) % DW, 3 * N + 2 * (N - 1 - a) + 1, 1'b0, 1'b0);
        end
        // failed 1->0 write: only element 3 catches it; at address 0 fail meets done (R9)
        for (int a = 0; a < N; a++) begin
            do_clear();
            run_march(3, a, 2, 5 * N + (N - 1 - a) + 1, 1'b0, 1'b0);
        end

        // R8: fail sticky through idle and a new start without clear
        repeat (5) @(negedge clk);
        chk("R8 fail held in idle", 32'(fail), 1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk("R8 fail held over restart", 32'(fail), 1);
        // R1: clear mid-run returns to idle and drops fail
        do_clear();
        repeat (3) @(negedge clk);
        chk("R1 stays idle we", 32'(mem_we), 0);
        chk("R1 stays idle re", 32'(mem_re), 0);
        // fresh clean run after the mid-run clear
        run_march(0, 0, 0, 0, 1'b0, 1'b1);

        summary();
        $finish;
    end
endmodule